// File: doc/BRIEF.md
# Interrupt Register Shadow Stack

This block keeps private copies of the processor's three working registers (accumulator, X and Y) so that an interrupt service routine may overwrite all of them freely. Each register has its own small hidden LIFO. A save request writes all three current register values into their stacks together in a single cycle. A restore request pops all three stacks together, and one clock later the popped values appear on the outputs with a load strobe so that the register file can reload itself.

A save request comes either from interrupt recognition (`irq_enter`) or from an explicit push-all instruction (`push_all`). A restore request comes either from the return-from-interrupt event (`irq_return`) or from an explicit pull-all instruction (`pull_all`). Software has no other way into the stacks. All three stacks share one fill counter, so they always hold the same number of entries. The counter is tracked by a three-state fill machine. Its states are `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. A save in `ST_EMPTY` moves to `ST_PARTIAL`. A save in `ST_PARTIAL` at level DEPTH-1 moves to `ST_FULL`. A restore in `ST_FULL` moves to `ST_PARTIAL`. A restore in `ST_PARTIAL` at level 1 moves to `ST_EMPTY`. Every other request leaves the state where it is: overflow, underflow, a clash, or a move within `ST_PARTIAL`.

The stack depth is a parameter, either 8 or 16. It is large enough for several levels of nested interrupts.

Top module: `reg_shadow_stack`

## Requirements
- R1: During reset and immediately after it, the three data outputs are zero, the strobe and all three flags are low, and the stacks are empty, so the first restore after reset underflows.
- R2: The accumulator, X and Y each have their own stack of DEPTH entries (DEPTH is 8 or 16). One shared fill level counts from 0 to DEPTH and never goes above DEPTH.
- R3: A save when the stacks are not full stores `acc_in`, `x_in` and `y_in` together in one cycle and raises the level by one. Exactly DEPTH saves fit in the stacks before an overflow.
- R4: A restore when the stacks are not empty pops all three stacks together and lowers the level by one. The values saved most recently appear on `acc_out`, `x_out` and `y_out` in the cycle after the request.
- R5: `irq_enter` and `push_all` are equivalent save sources, and `irq_return` and `pull_all` are equivalent restore sources. If both sources of the same kind are asserted in one cycle, they count as a single request.
- R6: `load_stb` is high for exactly one cycle, the cycle after each restore that is performed. While the strobe is low, the data outputs keep their previous values.
- R7: A save when the level equals DEPTH pulses `overflow` in the next cycle. The stack contents and the level are left unchanged.
- R8: A restore at level zero pulses `underflow` in the next cycle. It produces no strobe and leaves the data outputs unchanged.
- R9: A save and a restore requested in the same cycle pulse `clash_err` in the next cycle. Neither operation is performed.
- R10: Saves and restores may be interleaved in any order, and restores always return values in last-in, first-out order.
- R11: In any cycle, at most one of `load_stb`, `overflow`, `underflow` and `clash_err` is high. Each of them is high for one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_enter | input | 1 | Interrupt recognised; save all registers |
| irq_return | input | 1 | Return from interrupt; restore all registers |
| push_all | input | 1 | Push-all instruction; save all registers |
| pull_all | input | 1 | Pull-all instruction; restore all registers |
| acc_in | input | DATA_W | Current accumulator value |
| x_in | input | DATA_W | Current X value |
| y_in | input | DATA_W | Current Y value |
| acc_out | output | DATA_W | Restored accumulator value |
| x_out | output | DATA_W | Restored X value |
| y_out | output | DATA_W | Restored Y value |
| load_stb | output | 1 | Restored values are valid; register file reloads |
| overflow | output | 1 | Save was refused because the stacks are full |
| underflow | output | 1 | Restore was refused because the stacks are empty |
| clash_err | output | 1 | Save and restore came together; both were dropped |

## Verification
The assertions check the following on every cycle:
- the shared level stays between 0 and DEPTH;
- a save that fits raises the level by exactly one, and a save when full leaves the level alone and raises `overflow`;
- a restore at level zero yields `underflow` and no strobe;
- a clash yields `clash_err` and leaves the level unchanged;
- the strobe and the flags are mutually exclusive;
- the outputs hold their values whenever the strobe is low.

Only the bench's scenarios can show that the right data comes back. This covers last-in, first-out order across nested and interleaved sequences, the fact that an overflowing save does not corrupt stored entries, and the equivalence of the interrupt and instruction sources. The bench checks these against a queue model over both directed and random request streams.

// File: rtl/rss_pkg.sv
package rss_pkg;

    // Fill regime of the shared stack level
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;

    // Operation requested in the current cycle
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_SAVE    = 2'd1,
        OP_RESTORE = 2'd2,
        OP_CLASH   = 2'd3
    } stack_op_e;

    localparam int NUM_REGS = 3;
    localparam int REG_ACC  = 0;
    localparam int REG_X    = 1;
    localparam int REG_Y    = 2;

endpackage

// File: rtl/rss_req_decode.sv
module rss_req_decode
    import rss_pkg::*;
(
    input  logic      irq_enter,
    input  logic      irq_return,
    input  logic      push_all,
    input  logic      pull_all,
    output logic      save_req,
    output logic      restore_req,
    output stack_op_e op
);

    // Interrupt and instruction sources merge into one request of each kind
    always_comb begin
        save_req    = irq_enter  | push_all;
        restore_req = irq_return | pull_all;
        unique case ({save_req, restore_req})
            2'b10:   op = OP_SAVE;
            2'b01:   op = OP_RESTORE;
            2'b11:   op = OP_CLASH;
            default: op = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/rss_depth_fsm.sv
module rss_depth_fsm
    import rss_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stack_op_e        op,
    output logic             do_push,
    output logic             do_pop,
    output logic [PTR_W-1:0] fill_cnt,
    output logic             load_stb,
    output logic             overflow,
    output logic             underflow,
    output logic             clash_err
);

    localparam logic [PTR_W-1:0] LVL_LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] LVL_ONE  = PTR_W'(1);

    fill_state_e      state_q, state_d;
    logic [PTR_W-1:0] cnt_q, cnt_d;
    logic             ovf_d, unf_d, err_d;

    // Next-state and operation decode
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        do_push = 1'b0;
        do_pop  = 1'b0;
        ovf_d   = 1'b0;
        unf_d   = 1'b0;
        err_d   = 1'b0;
        if (op == OP_CLASH) begin
            err_d = 1'b1;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (op == OP_SAVE) begin
                        do_push = 1'b1;
                        cnt_d   = cnt_q + 1'b1;
                        state_d = ST_PARTIAL;
                    end else if (op == OP_RESTORE) begin
                        unf_d = 1'b1;
                    end
                end
                ST_PARTIAL: begin
                    if (op == OP_SAVE) begin
                        do_push = 1'b1;
                        cnt_d   = cnt_q + 1'b1;
                        if (cnt_q == LVL_LAST) begin
                            state_d = ST_FULL;
                        end
                    end else if (op == OP_RESTORE) begin
                        do_pop = 1'b1;
                        cnt_d  = cnt_q - 1'b1;
                        if (cnt_q == LVL_ONE) begin
                            state_d = ST_EMPTY;
                        end
                    end
                end
                ST_FULL: begin
                    if (op == OP_SAVE) begin
                        ovf_d = 1'b1;
                    end else if (op == OP_RESTORE) begin
                        do_pop  = 1'b1;
                        cnt_d   = cnt_q - 1'b1;
                        state_d = ST_PARTIAL;
                    end
                end
                default: begin
                    state_d = ST_EMPTY;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered strobe and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_stb  <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
            clash_err <= 1'b0;
        end else begin
            load_stb  <= do_pop;
            overflow  <= ovf_d;
            underflow <= unf_d;
            clash_err <= err_d;
        end
    end

    assign fill_cnt = cnt_q;

endmodule

// File: rtl/rss_lifo.sv
module rss_lifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PTR_W-1:0]  level,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [PTR_W-1:0]  level_m1;

    always_comb begin
        level_m1 = level - 1'b1;
        wr_idx   = level[IDX_W-1:0];
        rd_idx   = level_m1[IDX_W-1:0];
    end

    // Entries are only read after being written, so they need no reset
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (pop) begin
            dout <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/reg_shadow_stack.sv
module reg_shadow_stack
    import rss_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_enter,
    input  logic              irq_return,
    input  logic              push_all,
    input  logic              pull_all,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] x_out,
    output logic [DATA_W-1:0] y_out,
    output logic              load_stb,
    output logic              overflow,
    output logic              underflow,
    output logic              clash_err
);

    localparam int PTR_W = $clog2(DEPTH + 1);

    stack_op_e        op;
    logic             save_req, restore_req;
    logic             do_push, do_pop;
    logic [PTR_W-1:0] fill_cnt;
    logic [DATA_W-1:0] reg_in  [NUM_REGS];
    logic [DATA_W-1:0] reg_out [NUM_REGS];

    rss_req_decode u_decode (
        .irq_enter   (irq_enter),
        .irq_return  (irq_return),
        .push_all    (push_all),
        .pull_all    (pull_all),
        .save_req    (save_req),
        .restore_req (restore_req),
        .op          (op)
    );

    rss_depth_fsm #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .fill_cnt  (fill_cnt),
        .load_stb  (load_stb),
        .overflow  (overflow),
        .underflow (underflow),
        .clash_err (clash_err)
    );

    assign reg_in[REG_ACC] = acc_in;
    assign reg_in[REG_X]   = x_in;
    assign reg_in[REG_Y]   = y_in;

    // One private LIFO per saved register, all sharing the same level
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stack
        rss_lifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .PTR_W  (PTR_W)
        ) u_lifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (do_push),
            .pop   (do_pop),
            .level (fill_cnt),
            .din   (reg_in[g]),
            .dout  (reg_out[g])
        );
    end

    assign acc_out = reg_out[REG_ACC];
    assign x_out   = reg_out[REG_X];
    assign y_out   = reg_out[REG_Y];

endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              save_req,
    input logic              restore_req,
    input logic [PTR_W-1:0]  fill_cnt,
    input logic [DATA_W-1:0] acc_out,
    input logic [DATA_W-1:0] x_out,
    input logic [DATA_W-1:0] y_out,
    input logic              load_stb,
    input logic              overflow,
    input logic              underflow,
    input logic              clash_err
);

    localparam logic [PTR_W-1:0] LVL_MAX = PTR_W'(DEPTH);

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= LVL_MAX);

    a_r3_save_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && fill_cnt < LVL_MAX)
        |=> (fill_cnt == $past(fill_cnt) + 1'b1) && !overflow);

    a_r7_full_save_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && fill_cnt == LVL_MAX)
        |=> overflow && $stable(fill_cnt));

    a_r8_empty_restore_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && fill_cnt == '0)
        |=> underflow && !load_stb);

    a_r9_clash_drops_both: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> clash_err && !load_stb && $stable(fill_cnt));

    a_r11_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_stb, overflow, underflow, clash_err}));

    a_r6_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |-> $stable(acc_out) && $stable(x_out) && $stable(y_out));

endmodule

bind reg_shadow_stack rss_checker #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .PTR_W  (PTR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .fill_cnt    (fill_cnt),
    .acc_out     (acc_out),
    .x_out       (x_out),
    .y_out       (y_out),
    .load_stb    (load_stb),
    .overflow    (overflow),
    .underflow   (underflow),
    .clash_err   (clash_err)
);

// File: tb/test_reg_shadow_stack.sv
`timescale 1ns/1ps
module test_reg_shadow_stack;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              irq_enter = 1'b0, irq_return = 1'b0;
    logic              push_all = 1'b0, pull_all = 1'b0;
    logic [DATA_W-1:0] acc_in = '0, x_in = '0, y_in = '0;
    logic [DATA_W-1:0] acc_out, x_out, y_out;
    logic              load_stb, overflow, underflow, clash_err;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    // Reference model state
    logic [3*DATA_W-1:0] model_q[$];
    logic [3*DATA_W-1:0] exp_data = '0;
    bit exp_stb = 0, exp_ovf = 0, exp_unf = 0, exp_err = 0;

    always #4 clk = ~clk;

    reg_shadow_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_reg_shadow_stack (
        .clk(clk), .rst_n(rst_n),
        .irq_enter(irq_enter), .irq_return(irq_return),
        .push_all(push_all), .pull_all(pull_all),
        .acc_in(acc_in), .x_in(x_in), .y_in(y_in),
        .acc_out(acc_out), .x_out(x_out), .y_out(y_out),
        .load_stb(load_stb), .overflow(overflow),
        .underflow(underflow), .clash_err(clash_err)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        vectors++;
        check({tag, "/R4"}, "data", 32'({acc_out, x_out, y_out}), 32'(exp_data));
        check("R6", "load_stb", 32'(load_stb), 32'(exp_stb));
        check("R7", "overflow", 32'(overflow), 32'(exp_ovf));
        check("R8", "underflow", 32'(underflow), 32'(exp_unf));
        check("R9", "clash_err", 32'(clash_err), 32'(exp_err));
        check("R11", "outcome count",
              32'(int'(load_stb) + int'(overflow) + int'(underflow) + int'(clash_err)) > 32'd1
                  ? 32'd1 : 32'd0, 32'd0);
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(string tag, bit ie, bit ir, bit pa, bit pl,
                       logic [DATA_W-1:0] a, logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
        bit sv, rs;
        irq_enter = ie; irq_return = ir; push_all = pa; pull_all = pl;
        acc_in = a; x_in = x; y_in = y;
        @(posedge clk);
        sv = ie | pa;
        rs = ir | pl;
        exp_stb = 0; exp_ovf = 0; exp_unf = 0; exp_err = 0;
        if (sv && rs) begin
            exp_err = 1;
        end else if (sv) begin
            if (model_q.size() == DEPTH) exp_ovf = 1;
            else model_q.push_back({a, x, y});
        end else if (rs) begin
            if (model_q.size() == 0) exp_unf = 1;
            else begin
                exp_data = model_q.pop_back();
                exp_stb = 1;
            end
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state, checked while in reset and after release
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        compare_all("R1");
        // R1/R8: the first restore after reset underflows
        cyc("R1", 0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        idle("R8");

        // R3/R4: single save and restore through the interrupt path
        cyc("R3", 1, 0, 0, 0, 8'h11, 8'h22, 8'h33);
        idle("R3");
        cyc("R4", 0, 1, 0, 0, 8'hFF, 8'hFF, 8'hFF);
        idle("R6");
        idle("R6");

        // R5: instruction path is equivalent; both sources together count once
        cyc("R5", 0, 0, 1, 0, 8'hA1, 8'hA2, 8'hA3);
        cyc("R5", 1, 0, 1, 0, 8'hB1, 8'hB2, 8'hB3);
        cyc("R5", 0, 1, 0, 1, 8'h00, 8'h00, 8'h00);
        cyc("R5", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        cyc("R5", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);

        // R10: nested interrupts with interleaved restores
        cyc("R10", 1, 0, 0, 0, 8'h01, 8'h02, 8'h03);
        cyc("R10", 1, 0, 0, 0, 8'h04, 8'h05, 8'h06);
        cyc("R10", 0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        cyc("R10", 0, 0, 1, 0, 8'h07, 8'h08, 8'h09);
        cyc("R10", 0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        cyc("R10", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);

        // R9: clash drops both, with data present and level untouched
        cyc("R9", 1, 0, 0, 0, 8'h5A, 8'h5B, 8'h5C);
        cyc("R9", 1, 1, 0, 0, 8'hEE, 8'hEE, 8'hEE);
        cyc("R9", 0, 0, 1, 1, 8'hEE, 8'hEE, 8'hEE);
        cyc("R9", 0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        cyc("R9", 0, 1, 0, 0, 8'h00, 8'h00, 8'h00);

        // R2/R3/R7: fill to DEPTH exactly, then overflow twice
        for (int i = 0; i < DEPTH; i++)
            cyc("R3", i[0], 0, ~i[0], 0, 8'(8'h40 + i), 8'(8'h50 + i), 8'(8'h60 + i));
        cyc("R7", 1, 0, 0, 0, 8'hDE, 8'hAD, 8'hBE);
        cyc("R7", 0, 0, 1, 0, 8'hDE, 8'hAD, 8'hBE);
        idle("R7");
        // R7/R10: drain all, contents must be intact and in reverse order
        for (int i = 0; i < DEPTH; i++)
            cyc("R7", 0, i[0], 0, ~i[0], 8'h00, 8'h00, 8'h00);
        cyc("R8", 0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        cyc("R8", 0, 0, 0, 1, 8'h00, 8'h00, 8'h00);

        // R2/R10/R11: random request stream
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 9);
            cyc("R10", r < 3, r == 3 || r == 4, r == 5 || r == 8, r == 6 || r == 8 || r == 9,
                8'($urandom), 8'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule